// File: doc/BRIEF.md
# Two-Pin General-Purpose Port Control Register

This block is a single 8-bit control register, reached over a plain register bus (address, write strobe, write data, combinational read data), that owns two general-purpose digital pins. For each pin it stores a direction bit and a level bit. A pin set as an output is driven with its stored level. A pin set as an input returns its sampled level when the register is read, so the level fields show live pin state rather than stored state.

The same register holds three more controls: a ready-pin behaviour select, a reduced-power request and a synchronization enable. The first two are only exported as control outputs for other logic. When synchronization is enabled, the second pin leaves general-purpose use. Its output driver is switched off and its synchronized level is passed to a sync output for the filter and modulator logic elsewhere in the chip.

Pin inputs pass through a two-flop synchronizer before any logic uses them. Writing a level bit always updates the stored level, even for an input pin, so that value is in place if the pin is later turned into an output.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After a synchronous reset with steady pins, a read at address 0x1 returns 0x30 plus pin 0 level times 0x80 plus pin 1 level times 0x40, and both output enables are 0.
- R2: Register bit 5 is the pin 0 direction and bit 4 is the pin 1 direction. 1 means input and 0 means output. Output enable of a pin is the inverse of its direction bit, except as R6 says.
- R3: Bit 7 stores the pin 0 level and bit 6 stores the pin 1 level. After a write, the pin output values equal these stored bits.
- R4: When a pin is an input, its level bit on read shows that pin's input level as sampled two clock edges earlier. When a pin is an output, the bit shows the stored level.
- R5: Bit 1 is reserved. Writes to it have no effect and it always reads 0.
- R6: When bit 0 (sync enable) is 1, pin 1's output enable is 0, its read level is the synchronized input, and the sync output follows that level. When bit 0 is 0, the sync output is 0.
- R7: Writing a level bit of an input pin updates its stored level, which appears on the pin output value while the output enable stays 0.
- R8: Bit 3 (ready mode) and bit 2 (reduced power) read back as written and appear on their own control outputs.
- R9: Writes to any address other than 0x1 change nothing. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| pin_in | input | 2 | Raw pin input levels, index 0 = pin 0 |
| pin_out | output | 2 | Stored output levels |
| pin_oe | output | 2 | Pin output enables |
| rdy_all_mode | output | 1 | Ready-mode control |
| low_power | output | 1 | Reduced-power control |
| sync_enable | output | 1 | Sync function enabled |
| sync_level | output | 1 | Synchronized pin 1 level while sync is enabled, else 0 |

## Verification
A write takes effect on the clock edge that samples it. The bench drives writes at a falling edge and checks the enables, output values, control outputs and read data at the next falling edge, one rising edge later. A pin input change reaches the read data and the sync output only after the second rising edge. The bench therefore checks at the falling edge after one rising edge that the old value is still shown, and after two rising edges that the new one is. The sweep covers every write value with every pin pattern and waits two edges before it compares against the arithmetic model.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;

    localparam int ADDR_W     = 4;
    localparam int DATA_W     = 8;
    localparam int NPIN       = 2;
    localparam int SYNC_DEPTH = 2;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'h1;

    typedef struct packed {
        logic lvl0;     // bit 7
        logic lvl1;     // bit 6
        logic dir0;     // bit 5, 1 = input
        logic dir1;     // bit 4, 1 = input
        logic rdy_all;  // bit 3
        logic low_pwr;  // bit 2
        logic rsvd;     // bit 1, always 0
        logic sync_en;  // bit 0
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{lvl0: 1'b0, lvl1: 1'b0, dir0: 1'b1, dir1: 1'b1,
                                     rdy_all: 1'b0, low_pwr: 1'b0, rsvd: 1'b0,
                                     sync_en: 1'b0};

    function automatic ctrl_t sanitize(input logic [DATA_W-1:0] raw);
        ctrl_t c;
        c = ctrl_t'(raw);
        c.rsvd = 1'b0;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] compose_read(input ctrl_t c,
                                                       input logic [NPIN-1:0] view);
        ctrl_t r;
        r = c;
        r.lvl0 = view[0];
        r.lvl1 = view[1];
        r.rsvd = 1'b0;
        return DATA_W'(r);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) chain[0] <= d;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) chain[s] <= chain[s-1];
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_ctrl_store.sv
module gpio_ctrl_store
    import gpio_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= CTRL_RESET;
        else if (wr_en) q <= sanitize(wdata);
    end

    AST_DIRS_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) && !rst |-> (q.dir0 && q.dir1 && !q.sync_en)); // R1
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
    import gpio_pair_pkg::*;
(
    input  logic            dir0,
    input  logic            dir1,
    input  logic            lvl0,
    input  logic            lvl1,
    input  logic            sync_en,
    input  logic [NPIN-1:0] pin_sync,
    output logic [NPIN-1:0] oe,
    output logic [NPIN-1:0] drive,
    output logic [NPIN-1:0] view,
    output logic            sync_level
);
    logic p1_is_input;

    always_comb begin
        p1_is_input = dir1 | sync_en;
        oe[0]       = ~dir0;
        oe[1]       = ~p1_is_input;
        drive       = {lvl1, lvl0};
        view[0]     = dir0 ? pin_sync[0] : lvl0;
        view[1]     = p1_is_input ? pin_sync[1] : lvl1;
        sync_level  = sync_en & pin_sync[1];
    end

    always_comb begin
        assert (!(oe[1] && sync_en)); // R6
    end
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl
    import gpio_pair_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              rdy_all_mode,
    output logic              low_power,
    output logic              sync_enable,
    output logic              sync_level
);
    logic            hit;
    ctrl_t           ctrl;
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] view;

    assign hit = (bus_addr == CTRL_ADDR);

    gpio_in_sync #(.WIDTH(NPIN), .STAGES(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .d   (pin_in),
        .q   (pin_sync)
    );

    gpio_ctrl_store u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_we & hit),
        .wdata (bus_wdata),
        .q     (ctrl)
    );

    gpio_pin_mux u_mux (
        .dir0       (ctrl.dir0),
        .dir1       (ctrl.dir1),
        .lvl0       (ctrl.lvl0),
        .lvl1       (ctrl.lvl1),
        .sync_en    (ctrl.sync_en),
        .pin_sync   (pin_sync),
        .oe         (pin_oe),
        .drive      (pin_out),
        .view       (view),
        .sync_level (sync_level)
    );

    assign rdy_all_mode = ctrl.rdy_all;
    assign low_power    = ctrl.low_pwr;
    assign sync_enable  = ctrl.sync_en;
    assign bus_rdata    = hit ? compose_read(ctrl, view) : '0;

    AST_DIR_TO_OE: assert property (@(posedge clk) disable iff (rst)
        hit && bus_we |=> pin_oe[0] == !$past(bus_wdata[5])); // R2
    AST_WR_LEVEL: assert property (@(posedge clk) disable iff (rst)
        hit && bus_we |=> pin_out == {$past(bus_wdata[6]), $past(bus_wdata[7])}); // R3
    AST_IN_VIEW: assert property (@(posedge clk) disable iff (rst)
        hit && bus_rdata[5] && !$past(rst, 2) |-> bus_rdata[7] == $past(pin_in[0], 2)); // R4
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rdata[1]); // R5
    AST_SYNC_OFF: assert property (@(posedge clk) disable iff (rst)
        hit && bus_we && bus_wdata[0] |=> !pin_oe[1]); // R6
    AST_FOREIGN_WR: assert property (@(posedge clk) disable iff (rst)
        !hit && bus_we |=> $stable(pin_oe) && $stable(pin_out) && $stable(low_power)); // R9
endmodule

// File: tb/gpio_pair_ctrl_test.sv
module gpio_pair_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = 4'h1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pin_out, pin_oe;
    logic       rdy_all_mode, low_power, sync_enable, sync_level;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    gpio_pair_ctrl uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .rdy_all_mode(rdy_all_mode),
        .low_power(low_power), .sync_enable(sync_enable), .sync_level(sync_level)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 4'h1;
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] st, input logic [1:0] pins);
        logic [7:0] r;
        r = st & 8'hFD;
        if (st[5]) r[7] = pins[0];
        if (st[4] || st[0]) r[6] = pins[1];
        return r;
    endfunction

    initial begin
        #4_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] st;
        pin_in = 2'b01;
        step(4);
        rst = 1'b0;
        step(1);
        // R1: reset value with pin0=1, pin1=0
        check("R1 read", bus_rdata, 8'hB0);
        check("R1 oe", {6'd0, pin_oe}, 8'h00);
        pin_in = 2'b10;
        step(1);
        check("R4 one edge", bus_rdata, 8'hB0);
        step(1);
        check("R4 two edges", bus_rdata, 8'h70);

        // R7: input pin keeps stored level
        wr(4'h1, 8'hB0);
        check("R7 out", {6'd0, pin_out}, 8'h01);
        check("R7 oe", {6'd0, pin_oe}, 8'h00);
        wr(4'h1, 8'h90);
        check("R7 switch", {6'd0, pin_oe[0], pin_out[0]}, 8'h03);

        // R9: foreign address
        st = 8'h90;
        for (int a = 0; a < 16; a++) begin
            if (a == 1) continue;
            wr(4'(a), 8'h2D);
            bus_addr = 4'(a);
            step(0);
            #1;
            check("R9 read", bus_rdata, 8'h00);
            bus_addr = 4'h1;
            #1;
            check("R9 state", bus_rdata, model_read(st, pin_in));
        end

        // sweep: R2 R3 R4 R5 R6 R8
        for (int d = 0; d < 256; d++) begin
            for (int p = 0; p < 4; p++) begin
                pin_in = 2'(p);
                wr(4'h1, 8'(d));
                step(1);
                st = 8'(d) & 8'hFD;
                check("R4 R5 read", bus_rdata, model_read(st, pin_in));
                check("R2 oe", {6'd0, pin_oe},
                      {6'd0, ~(st[4] | st[0]), ~st[5]});
                check("R3 R7 out", {6'd0, pin_out}, {6'd0, st[6], st[7]});
                check("R8 ctrl", {5'd0, rdy_all_mode, low_power, sync_enable},
                      {5'd0, st[3], st[2], st[0]});
                check("R6 sync", {7'd0, sync_level}, {7'd0, st[0] & pin_in[1]});
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule